// File: doc/BRIEF.md
# Interrupt Entry Bus Sequencer

This block is the interrupt-entry control path of a small 8-bit processor core with a 16-bit address bus and a stack held in a fixed memory page. At each instruction boundary, when the core flags the final cycle of an instruction, the block samples a level-sensitive interrupt request together with the interrupt-disable bit of the status byte. It then decides whether the next opcode fetch is taken over by the interrupt.

When it takes over, the block owns the bus for seven cycles. The opcode fetch still happens on the bus with SYNC high, but the core is told to load the break opcode (0x00) instead of the byte it reads. The same address is then read again. The return address and the status byte are pushed, and the handler address is fetched from the top of memory. While `busy` is high, the core stalls and takes its PC, stack pointer and interrupt-disable updates from the block's strobes. The bus outputs are meaningful only while `busy` is high.

An instruction that ends as a taken branch does not open a recognition window. A request raised during a branch is therefore honoured only after the instruction at the branch target has completed.

Top module: `irq_entry_seq`

## Requirements
- R1: When `instr_last` is high, `busy` is low, `irq` is high, `p_in[2]` is 0 and `br_taken` is low, the following cycle is the first entry cycle (`busy` and `sync` both high). The entry always lasts exactly seven consecutive cycles.
- R2: While `p_in[2]` (interrupt disable) is 1 at every boundary, no entry occurs, whatever `irq` does.
- R3: Entry cycle 1 reads (`bus_we`=0) at `pc_in` with `sync`=1 and `op_force`=1, and `op_force_val` is 0x00.
- R4: Entry cycle 2 reads again from the same address as cycle 1, with `sync`=0 and `op_force`=0.
- R5: Entry cycles 3, 4 and 5 write, in that order, PC[15:8], PC[7:0] and the status byte with bit 4 forced to 0 and bit 5 forced to 1. The address is 0x0100 plus the current stack pointer. Each of these cycles pulses `sp_we` with `sp_out` = `sp_in` - 1. The pushed PC is the unadjusted address fetched in cycle 1.
- R6: Entry cycle 6 reads 0xFFFE. Entry cycle 7 reads 0xFFFF and pulses `pc_we` with `pc_out` = {byte read in cycle 7, byte read in cycle 6}, and also pulses `iflag_set`.
- R7: The cycle after entry cycle 7 has `busy` low, so the core fetches normally at the handler address.
- R8: A boundary where `br_taken` is high never starts an entry. A pending request is taken at the end of the next instruction.
- R9: Between `irq` first going high and the 0xFFFE read, the latency is 6 cycles when `irq` rises in a boundary cycle. It grows by one for each cycle the request arrives earlier within the instruction, so a 2-cycle instruction gives 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Level-sensitive interrupt request, active high |
| pc_in | input | 16 | Core PC; at a boundary, the address of the next opcode |
| sp_in | input | 8 | Core stack pointer |
| p_in | input | 8 | Core status byte; bit 2 is interrupt disable |
| instr_last | input | 1 | Current cycle is the last cycle of an instruction |
| br_taken | input | 1 | Qualifies `instr_last`: the finishing instruction is a taken branch |
| data_in | input | 8 | Read data bus |
| bus_addr | output | 16 | Address during entry |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_wdata | output | 8 | Write data during push cycles |
| sync | output | 1 | Opcode-fetch marker for the taken-over fetch |
| busy | output | 1 | Block owns the bus; core stalls |
| op_force | output | 1 | Core must load `op_force_val` instead of the fetched byte |
| op_force_val | output | 8 | Forced opcode (0x00) |
| pc_we | output | 1 | Load `pc_out` into the core PC |
| pc_out | output | 16 | Handler address |
| sp_we | output | 1 | Load `sp_out` into the core stack pointer |
| sp_out | output | 8 | Decremented stack pointer |
| iflag_set | output | 1 | Set interrupt disable in the core status byte |

## Verification
Two decisions can fall on one boundary cycle: whether to take the interrupt, and whether the finishing instruction is a taken branch that suppresses it. A request can also rise in the very cycle it is sampled. The bench sweeps the arrival cycle of `irq` over every cycle of a stream of 2-cycle instructions, both with and without a leading 3-cycle taken branch. It computes the boundary where entry must start, the pushed PC and the latency to the 0xFFFE read arithmetically, then compares every entry cycle's bus fields against them. A masked run confirms that `busy` never rises.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    localparam logic [DATA_W-1:0] OPC_BREAK = 8'h00;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_REREAD,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_ST,
        ST_VEC_LO,
        ST_VEC_HI
    } ent_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic              sync;
    } bus_cyc_t;

    function automatic logic [DATA_W-1:0] stacked_status(
        input logic [DATA_W-1:0] p,
        input int                brk_bit,
        input int                one_bit
    );
        logic [DATA_W-1:0] r;
        r          = p;
        r[brk_bit] = 1'b0;
        r[one_bit] = 1'b1;
        return r;
    endfunction

    function automatic logic [ADDR_W-1:0] stack_addr(
        input logic [DATA_W-1:0] page,
        input logic [DATA_W-1:0] sp
    );
        return {page, sp};
    endfunction

endpackage

// File: rtl/irq_take_gate.sv
module irq_take_gate #(
    parameter int IDIS_BIT = 2
) (
    input  logic       instr_last,
    input  logic       br_taken,
    input  logic       busy,
    input  logic       irq,
    input  logic [7:0] p_in,
    output logic       take
);
    // Decision is made only at a boundary that is not a taken branch.
    always_comb begin
        take = instr_last && !busy && !br_taken && irq && !p_in[IDIS_BIT];
    end
endmodule

// File: rtl/irq_entry_fsm.sv
module irq_entry_fsm
    import irq_entry_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       take,
    output ent_state_e st
);
    ent_state_e st_nx;

    always_comb begin
        unique case (st)
            ST_IDLE:    st_nx = take ? ST_FETCH : ST_IDLE;
            ST_FETCH:   st_nx = ST_REREAD;
            ST_REREAD:  st_nx = ST_PUSH_HI;
            ST_PUSH_HI: st_nx = ST_PUSH_LO;
            ST_PUSH_LO: st_nx = ST_PUSH_ST;
            ST_PUSH_ST: st_nx = ST_VEC_LO;
            ST_VEC_LO:  st_nx = ST_VEC_HI;
            ST_VEC_HI:  st_nx = ST_IDLE;
            default:    st_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end
endmodule

// File: rtl/irq_entry_bus.sv
module irq_entry_bus
    import irq_entry_pkg::*;
#(
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] VEC_ADDR   = 16'hFFFE,
    parameter int          BRK_BIT    = 4,
    parameter int          ONE_BIT    = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  ent_state_e  st,
    input  logic [15:0] pc_in,
    input  logic [7:0]  sp_in,
    input  logic [7:0]  p_in,
    input  logic [7:0]  data_in,
    output bus_cyc_t    cyc,
    output logic        op_force,
    output logic        pc_we,
    output logic [15:0] pc_out,
    output logic        sp_we,
    output logic [7:0]  sp_out,
    output logic        iflag_set
);
    localparam logic [15:0] VEC_ADDR_HI = VEC_ADDR + 16'd1;

    logic [7:0] vec_lo_q;

    always_ff @(posedge clk) begin
        if (rst)                  vec_lo_q <= '0;
        else if (st == ST_VEC_LO) vec_lo_q <= data_in;
    end

    always_comb begin
        cyc       = '0;
        op_force  = 1'b0;
        pc_we     = 1'b0;
        pc_out    = {data_in, vec_lo_q};
        sp_we     = 1'b0;
        sp_out    = sp_in - 8'd1;
        iflag_set = 1'b0;
        unique case (st)
            ST_FETCH: begin
                cyc.addr = pc_in;
                cyc.sync = 1'b1;
                op_force = 1'b1;
            end
            ST_REREAD: cyc.addr = pc_in;
            ST_PUSH_HI, ST_PUSH_LO, ST_PUSH_ST: begin
                cyc.addr = stack_addr(STACK_PAGE, sp_in);
                cyc.we   = 1'b1;
                sp_we    = 1'b1;
                if (st == ST_PUSH_HI)      cyc.wdata = pc_in[15:8];
                else if (st == ST_PUSH_LO) cyc.wdata = pc_in[7:0];
                else cyc.wdata = stacked_status(p_in, BRK_BIT, ONE_BIT);
            end
            ST_VEC_LO: cyc.addr = VEC_ADDR;
            ST_VEC_HI: begin
                cyc.addr  = VEC_ADDR_HI;
                pc_we     = 1'b1;
                iflag_set = 1'b1;
            end
            default: ;
        endcase
    end

    // R5: a push must never carry the break bit set
    p_status_r5: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PUSH_ST) |-> (cyc.we && !cyc.wdata[BRK_BIT] && cyc.wdata[ONE_BIT]));
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter logic [7:0]  STACK_PAGE = 8'h01,
    parameter logic [15:0] VEC_ADDR   = 16'hFFFE,
    parameter int          IDIS_BIT   = 2,
    parameter int          BRK_BIT    = 4,
    parameter int          ONE_BIT    = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        irq,
    input  logic [15:0] pc_in,
    input  logic [7:0]  sp_in,
    input  logic [7:0]  p_in,
    input  logic        instr_last,
    input  logic        br_taken,
    input  logic [7:0]  data_in,
    output logic [15:0] bus_addr,
    output logic        bus_we,
    output logic [7:0]  bus_wdata,
    output logic        sync,
    output logic        busy,
    output logic        op_force,
    output logic [7:0]  op_force_val,
    output logic        pc_we,
    output logic [15:0] pc_out,
    output logic        sp_we,
    output logic [7:0]  sp_out,
    output logic        iflag_set
);
    ent_state_e st;
    bus_cyc_t   cyc;
    logic       take;

    assign busy         = (st != ST_IDLE);
    assign bus_addr     = cyc.addr;
    assign bus_we       = cyc.we;
    assign bus_wdata    = cyc.wdata;
    assign sync         = cyc.sync;
    assign op_force_val = OPC_BREAK;

    irq_take_gate #(.IDIS_BIT(IDIS_BIT)) u_gate (
        .instr_last (instr_last),
        .br_taken   (br_taken),
        .busy       (busy),
        .irq        (irq),
        .p_in       (p_in),
        .take       (take)
    );

    irq_entry_fsm u_fsm (
        .clk  (clk),
        .rst  (rst),
        .take (take),
        .st   (st)
    );

    irq_entry_bus #(
        .STACK_PAGE (STACK_PAGE),
        .VEC_ADDR   (VEC_ADDR),
        .BRK_BIT    (BRK_BIT),
        .ONE_BIT    (ONE_BIT)
    ) u_bus (
        .clk       (clk),
        .rst       (rst),
        .st        (st),
        .pc_in     (pc_in),
        .sp_in     (sp_in),
        .p_in      (p_in),
        .data_in   (data_in),
        .cyc       (cyc),
        .op_force  (op_force),
        .pc_we     (pc_we),
        .pc_out    (pc_out),
        .sp_we     (sp_we),
        .sp_out    (sp_out),
        .iflag_set (iflag_set)
    );

    p_take_r1: assert property (@(posedge clk) disable iff (rst)
        (instr_last && !busy && irq && !p_in[IDIS_BIT] && !br_taken) |=> (busy && sync));

    p_mask_r2: assert property (@(posedge clk) disable iff (rst)
        (instr_last && !busy && p_in[IDIS_BIT]) |=> !busy);

    p_reread_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && sync && $stable(pc_in)) |=> (busy && !sync && !bus_we && !op_force));

    p_vector_r6: assert property (@(posedge clk) disable iff (rst)
        pc_we |-> (iflag_set && !bus_we && bus_addr == VEC_ADDR + 16'd1));

    p_exit_r7: assert property (@(posedge clk) disable iff (rst)
        iflag_set |=> !busy);

    p_branch_r8: assert property (@(posedge clk) disable iff (rst)
        (instr_last && !busy && br_taken) |=> !busy);
endmodule

// File: tb/irq_entry_seq_tb.sv
module irq_entry_seq_tb;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  sp_in = '0;
    logic [7:0]  p_in = '0;
    logic        instr_last = 1'b0;
    logic        br_taken = 1'b0;
    logic [7:0]  data_in = '0;
    logic [15:0] bus_addr;
    logic        bus_we;
    logic [7:0]  bus_wdata;
    logic        sync;
    logic        busy;
    logic        op_force;
    logic [7:0]  op_force_val;
    logic        pc_we;
    logic [15:0] pc_out;
    logic        sp_we;
    logic [7:0]  sp_out;
    logic        iflag_set;

    int checks = 0;
    int errors = 0;

    always #(PERIOD/2) clk = ~clk;

    irq_entry_seq u_dut (
        .clk(clk), .rst(rst), .irq(irq), .pc_in(pc_in), .sp_in(sp_in),
        .p_in(p_in), .instr_last(instr_last), .br_taken(br_taken),
        .data_in(data_in), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .sync(sync), .busy(busy), .op_force(op_force),
        .op_force_val(op_force_val), .pc_we(pc_we), .pc_out(pc_out),
        .sp_we(sp_we), .sp_out(sp_out), .iflag_set(iflag_set)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // offs: cycle where irq rises; brf: first instruction is a taken 3-cycle branch
    task automatic scenario(input int offs, input bit brf, input bit masked);
        logic [15:0] m_pc = 16'h0200;
        logic [7:0]  m_sp = 8'hFD;
        logic [7:0]  m_p  = masked ? 8'hD7 : 8'hD3;
        int cnt = 0, idx = 0, ent = 0, c, bad_win = 0;
        bit irq_done = 0;
        logic [15:0] pc_exp;
        logic [7:0]  st_exp;
        if (!brf) c = (offs % 2 == 1) ? offs : offs + 1;
        else      c = (offs <= 4) ? 4 : ((offs % 2 == 0) ? offs : offs + 1);
        pc_exp = brf ? 16'h0201 + 16'(c) : 16'h0201 + 16'(c);
        st_exp = (m_p & 8'hEF) | 8'h20;
        rst = 1'b1; irq = 1'b0; instr_last = 1'b0; br_taken = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!busy && !pc_we && !sp_we && !iflag_set, "R1 reset idle", busy, 0);
        for (int cyc = 0; cyc < 40; cyc++) begin
            bit is_br, il;
            int len;
            @(posedge clk); #1;
            rst = 1'b0;
            is_br = brf && idx == 0;
            len = is_br ? 3 : 2;
            il = !busy && cnt == len - 1;
            instr_last = il;
            br_taken = il && is_br;
            irq = (cyc >= offs) && !irq_done;
            pc_in = m_pc; sp_in = m_sp; p_in = m_p;
            #1;
            data_in = (bus_addr == 16'hFFFE) ? 8'h34 : (bus_addr == 16'hFFFF) ? 8'h12 : 8'hEA;
            @(negedge clk);
            if (masked) begin
                if (busy) bad_win++;
            end else begin
                if (busy != (cyc >= c + 1 && cyc <= c + 7)) bad_win++;
                if (busy) begin
                    case (ent)
                        0: begin
                            chk(bus_addr == pc_exp && !bus_we && sync, "R3 fetch cycle", bus_addr, pc_exp);
                            chk(op_force && op_force_val == 8'h00, "R3 forced opcode", op_force_val, 0);
                        end
                        1: chk(bus_addr == pc_exp && !bus_we && !sync && !op_force, "R4 repeated read", bus_addr, pc_exp);
                        2: chk(bus_we && bus_addr == 16'h01FD && bus_wdata == pc_exp[15:8]
                               && sp_we && sp_out == 8'hFC, "R5 push pc high", bus_wdata, pc_exp[15:8]);
                        3: chk(bus_we && bus_addr == 16'h01FC && bus_wdata == pc_exp[7:0]
                               && sp_we && sp_out == 8'hFB, "R5 push pc low", bus_wdata, pc_exp[7:0]);
                        4: chk(bus_we && bus_addr == 16'h01FB && bus_wdata == st_exp
                               && sp_we && sp_out == 8'hFA, "R5 push status", bus_wdata, st_exp);
                        5: begin
                            chk(!bus_we && bus_addr == 16'hFFFE, "R6 vector low", bus_addr, 16'hFFFE);
                            chk(cyc - offs == c + 6 - offs,
                                brf ? "R8 deferred latency" : "R9 latency", cyc - offs, c + 6 - offs);
                        end
                        6: chk(!bus_we && bus_addr == 16'hFFFF && pc_we && pc_out == 16'h1234
                               && iflag_set, "R6 vector high", pc_out, 16'h1234);
                        default: ;
                    endcase
                    ent++;
                end
                if (cyc == c + 8) chk(!busy && m_pc == 16'h1234, "R7 handler fetch", m_pc, 16'h1234);
            end
            if (pc_we) m_pc = pc_out;
            if (sp_we) m_sp = sp_out;
            if (iflag_set) begin m_p = m_p | 8'h04; irq_done = 1; end
            if (il) begin m_pc = m_pc + 16'(len); idx++; cnt = 0; end
            else if (busy) cnt = 0;
            else cnt++;
        end
        chk(bad_win == 0, masked ? "R2 masked no entry" : (brf ? "R8 entry window" : "R1 entry window"),
            bad_win, 0);
    endtask

    initial begin
        #(PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int o = 0; o < 6; o++) scenario(o, 1'b0, 1'b0);
        for (int o = 0; o < 7; o++) scenario(o, 1'b1, 1'b0);
        scenario(0, 1'b0, 1'b1);
        scenario(3, 1'b1, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule